// File: doc/BRIEF.md
# Neighbor Buffer Controller for Frame/Field Macroblock Pairs

This block steers the small neighbor-pixel stores that an intra predictor reads when a picture mixes frame-coded and field-coded macroblock pairs. For every finished 4x4 block it raises one enable per upper-buffer sub-row and one per left-buffer pixel entry that must take the reconstructed pixels. It also decides, at the start of each pair and again before its bottom macroblock, whether the first corner pixel can be reused or has to be fetched again.

The row above is held in two line memories used alternately. While one bank feeds the current pair's upper neighbors, the other bank is filled for the following pair. The controller issues the read requests that load the upper buffer at the start of a pair. It supplies the bank selects and the pair-column addresses, and it raises a hold flag that keeps the line-memory output steady for as long as the predictor still reads it directly. The buffers' pixel storage, the prediction arithmetic and the external memory traffic sit outside this block.

Because the pixels are rearranged when they are written, the update pattern depends only on the mode of the current pair. The mode of the left pair matters only for the corner decision made at the start of the pair.

Top module: `nbr_buf_ctrl`

## Requirements
- R1: The current and left pair modes are sampled on `pair_start_i` (1 = field, 0 = frame). Later changes on `pair_field_i` or `left_field_i` have no effect until the next `pair_start_i`.
- R2: In the cycle after `pair_start_i`, the upper-buffer load begins. A frame pair issues one line-memory read with row 0 and load mask 0x0F. A field pair issues two reads in consecutive cycles: row 0 with mask 0x0F, then row 1 with mask 0xF0. After the reads, `lm_rd_en_o` is low.
- R3: In a frame pair, a block in column c raises upper update bits c and c+4. These are the sub-rows of both upper rows.
- R4: In a field pair, a block in column c raises only upper bit c when it is in the top macroblock, and only bit c+4 when it is in the bottom macroblock.
- R5: In a frame pair, a block in block-row r raises left bits 4r to 4r+3. These are all four entries of sub-column r.
- R6: In a field pair, a top-macroblock block in row r raises left entries one and three (bits 4r and 4r+2). A bottom-macroblock block raises entries two and four (bits 4r+1 and 4r+3).
- R7: After `pair_start_i`, `corner_reuse_o` is 1 when the current and left modes match. Otherwise `corner_reload_o` pulses for one cycle and `corner_reuse_o` is 0.
- R8: After `bot_start_i`, a frame pair sets `corner_reuse_o` to 1. A field pair sets `corner_reuse_o` to 0 and pulses `corner_reload_o`.
- R9: `lm_hold_o` rises after `pair_start_i` and stays high until the fifth block of the pair has been accepted. It falls in the cycle that follows that fifth block.
- R10: Each `pair_start_i` flips `lm_rd_bank_o` (bank 0 for the first pair after reset) and advances `lm_rd_addr_o` by one (0 for the first pair), wrapping at PAIRS_PER_ROW. `lm_wr_bank_o` is the other bank, and `lm_wr_addr_o` is the next column, also wrapping.
- R11: After reset, all load and update enables, `lm_rd_en_o`, `lm_hold_o`, `corner_reuse_o` and `corner_reload_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pair_start_i | input | 1 | Start of a new macroblock pair |
| pair_field_i | input | 1 | Current pair mode, 1 = field |
| left_field_i | input | 1 | Left pair mode, 1 = field |
| bot_start_i | input | 1 | Start of the bottom macroblock |
| blk_valid_i | input | 1 | A 4x4 block was reconstructed |
| blk_bot_i | input | 1 | Block belongs to the bottom macroblock |
| blk_row_i | input | RW | Block row inside the macroblock |
| blk_col_i | input | RW | Block column inside the macroblock |
| upper_ld_o | output | 2*MB_BLKS | Upper sub-rows loaded from line memory |
| upper_upd_o | output | 2*MB_BLKS | Upper sub-rows written by the block |
| left_upd_o | output | MB_BLKS*BLK_PIX | Left entries written by the block |
| corner_reuse_o | output | 1 | First corner pixel is kept |
| corner_reload_o | output | 1 | First corner pixel must be fetched |
| lm_rd_en_o | output | 1 | Line-memory read request |
| lm_rd_row_o | output | 1 | Upper row being read |
| lm_rd_bank_o | output | 1 | Bank serving the current pair |
| lm_rd_addr_o | output | AW | Pair column being read |
| lm_wr_bank_o | output | 1 | Bank being filled |
| lm_wr_addr_o | output | AW | Pair column being filled |
| lm_hold_o | output | 1 | Keep line-memory output steady |

## Verification
The bench builds the block with PAIRS_PER_ROW = 3. This lets the line-memory column address wrap after a handful of pairs while the bank toggles on every pair. MB_BLKS, BLK_PIX and HOLD_BLKS keep their defaults of 4, 4 and 5, so every upper and left bit position is reachable and the hold release after the fifth block is observed inside the top macroblock. The bench walks all four pairings of current and left mode, and in some pairs it flips the mode inputs mid-pair to show that the sampled mode is the one in force.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  typedef enum logic {PAIR_FRAME = 1'b0, PAIR_FIELD = 1'b1} pair_mode_e;
endpackage

// File: rtl/nbc_mode_ctl.sv
module nbc_mode_ctl
  import nbc_pkg::*;
#(
  parameter int PAIRS = 120,
  localparam int AW = $clog2(PAIRS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pair_start,
  input  logic          bot_start,
  input  logic          pair_field,
  input  logic          left_field,
  output logic          cur_field,
  output logic          corner_reuse,
  output logic          corner_reload,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr
);
  pair_mode_e    cur_mode_q;
  logic          reuse_q, reload_q, bank_q;
  logic [AW-1:0] idx_q;

  function automatic logic [AW-1:0] step_idx(input logic [AW-1:0] i);
    return (i == AW'(PAIRS - 1)) ? '0 : i + AW'(1);
  endfunction

  // corner kept at pair start when modes agree, before bottom MB when frame
  function automatic logic keep_corner(input logic at_start, input logic cur, input logic left);
    return at_start ? (cur == left) : !cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_mode_q <= PAIR_FRAME;
      reuse_q    <= 1'b0;
      reload_q   <= 1'b0;
      bank_q     <= 1'b1;
      idx_q      <= AW'(PAIRS - 1);
    end else if (pair_start) begin
      cur_mode_q <= pair_mode_e'(pair_field);
      reuse_q    <= keep_corner(1'b1, pair_field, left_field);
      reload_q   <= !keep_corner(1'b1, pair_field, left_field);
      bank_q     <= !bank_q;
      idx_q      <= step_idx(idx_q);
    end else if (bot_start) begin
      reuse_q    <= keep_corner(1'b0, cur_field, 1'b0);
      reload_q   <= !keep_corner(1'b0, cur_field, 1'b0);
    end else begin
      reload_q   <= 1'b0;
    end
  end

  assign cur_field     = (cur_mode_q == PAIR_FIELD);
  assign corner_reuse  = reuse_q;
  assign corner_reload = reload_q;
  assign rd_bank       = bank_q;
  assign rd_addr       = idx_q;
  assign wr_addr       = step_idx(idx_q);

  a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_start |=> $stable(cur_field));
  a_r8_bottom_corner: assert property (@(posedge clk) disable iff (!rst_n)
    bot_start && !pair_start |=> corner_reload == cur_field);
  a_r10_bank_flip: assert property (@(posedge clk) disable iff (!rst_n)
    pair_start |=> rd_bank != $past(rd_bank));
  a_r7_corner_excl: assert property (@(posedge clk) disable iff (!rst_n)
    corner_reload |-> !corner_reuse);
endmodule

// File: rtl/nbc_upper_ctl.sv
module nbc_upper_ctl #(
  parameter int MB_BLKS   = 4,
  parameter int HOLD_BLKS = 5,
  localparam int RW = $clog2(MB_BLKS),
  localparam int UW = 2 * MB_BLKS,
  localparam int HW = $clog2(HOLD_BLKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pair_start,
  input  logic          pair_field,
  input  logic          cur_field,
  input  logic          blk_valid,
  input  logic          blk_bot,
  input  logic [RW-1:0] blk_col,
  output logic          ld_en,
  output logic          ld_row,
  output logic [UW-1:0] ld_mask,
  output logic [UW-1:0] upd_mask,
  output logic          hold
);
  logic          ld_act_q, ld_row_q, ld_two_q, hold_q;
  logic [HW-1:0] cnt_q;

  function automatic logic [UW-1:0] upd_bits(input logic field, input logic bot,
                                             input logic [RW-1:0] col);
    logic [UW-1:0] m = '0;
    if (field) begin
      m[int'(col) + (bot ? MB_BLKS : 0)] = 1'b1;
    end else begin
      m[int'(col)]           = 1'b1;
      m[int'(col) + MB_BLKS] = 1'b1;
    end
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_act_q <= 1'b0;
      ld_row_q <= 1'b0;
      ld_two_q <= 1'b0;
    end else if (pair_start) begin
      ld_act_q <= 1'b1;
      ld_row_q <= 1'b0;
      ld_two_q <= pair_field;
    end else if (ld_act_q) begin
      if (ld_two_q && !ld_row_q) ld_row_q <= 1'b1;
      else                       ld_act_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pair_start) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (blk_valid && hold_q) begin
      cnt_q <= cnt_q + HW'(1);
      if (cnt_q == HW'(HOLD_BLKS - 1)) hold_q <= 1'b0;
    end
  end

  assign ld_en    = ld_act_q;
  assign ld_row   = ld_act_q & ld_row_q;
  assign ld_mask  = !ld_act_q ? '0 :
                    ld_row_q  ? {{MB_BLKS{1'b1}}, {MB_BLKS{1'b0}}}
                              : {{MB_BLKS{1'b0}}, {MB_BLKS{1'b1}}};
  assign upd_mask = blk_valid ? upd_bits(cur_field, blk_bot, blk_col) : '0;
  assign hold     = hold_q;

  a_r2_frame_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && !ld_two_q && !pair_start |=> !ld_en);
  a_r3_frame_two_subrows: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !cur_field |-> $countones(upd_mask) == 2);
  a_r4_field_one_subrow: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && cur_field |-> $countones(upd_mask) == 1);
  a_r9_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(blk_valid));
  a_r9_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
    pair_start |=> hold);
endmodule

// File: rtl/nbc_left_ctl.sv
module nbc_left_ctl #(
  parameter int MB_BLKS = 4,
  parameter int BLK_PIX = 4,
  localparam int RW = $clog2(MB_BLKS),
  localparam int LW = MB_BLKS * BLK_PIX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cur_field,
  input  logic          blk_valid,
  input  logic          blk_bot,
  input  logic [RW-1:0] blk_row,
  output logic [LW-1:0] upd_mask
);
  // field pairs interleave: even entries from top MB, odd entries from bottom
  function automatic logic [LW-1:0] left_bits(input logic field, input logic bot,
                                              input logic [RW-1:0] row);
    logic [LW-1:0] m = '0;
    for (int e = 0; e < BLK_PIX; e++) begin
      if (!field || ((e % 2) == int'(bot))) m[int'(row) * BLK_PIX + e] = 1'b1;
    end
    return m;
  endfunction

  assign upd_mask = blk_valid ? left_bits(cur_field, blk_bot, blk_row) : '0;

  a_r5_frame_full_column: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && !cur_field |-> $countones(upd_mask) == BLK_PIX);
  a_r6_field_half_column: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid && cur_field |-> $countones(upd_mask) == BLK_PIX / 2);
  a_r11_idle_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_valid |-> upd_mask == '0);
endmodule

// File: rtl/nbr_buf_ctrl.sv
module nbr_buf_ctrl #(
  parameter int MB_BLKS       = 4,
  parameter int BLK_PIX       = 4,
  parameter int HOLD_BLKS     = 5,
  parameter int PAIRS_PER_ROW = 120,
  localparam int RW = $clog2(MB_BLKS),
  localparam int UW = 2 * MB_BLKS,
  localparam int LW = MB_BLKS * BLK_PIX,
  localparam int AW = $clog2(PAIRS_PER_ROW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pair_start_i,
  input  logic          pair_field_i,
  input  logic          left_field_i,
  input  logic          bot_start_i,
  input  logic          blk_valid_i,
  input  logic          blk_bot_i,
  input  logic [RW-1:0] blk_row_i,
  input  logic [RW-1:0] blk_col_i,
  output logic [UW-1:0] upper_ld_o,
  output logic [UW-1:0] upper_upd_o,
  output logic [LW-1:0] left_upd_o,
  output logic          corner_reuse_o,
  output logic          corner_reload_o,
  output logic          lm_rd_en_o,
  output logic          lm_rd_row_o,
  output logic          lm_rd_bank_o,
  output logic [AW-1:0] lm_rd_addr_o,
  output logic          lm_wr_bank_o,
  output logic [AW-1:0] lm_wr_addr_o,
  output logic          lm_hold_o
);
  logic cur_field;

  nbc_mode_ctl #(.PAIRS(PAIRS_PER_ROW)) u_mode (
    .clk(clk), .rst_n(rst_n), .pair_start(pair_start_i), .bot_start(bot_start_i),
    .pair_field(pair_field_i), .left_field(left_field_i), .cur_field(cur_field),
    .corner_reuse(corner_reuse_o), .corner_reload(corner_reload_o),
    .rd_bank(lm_rd_bank_o), .rd_addr(lm_rd_addr_o), .wr_addr(lm_wr_addr_o));

  nbc_upper_ctl #(.MB_BLKS(MB_BLKS), .HOLD_BLKS(HOLD_BLKS)) u_upper (
    .clk(clk), .rst_n(rst_n), .pair_start(pair_start_i), .pair_field(pair_field_i),
    .cur_field(cur_field), .blk_valid(blk_valid_i), .blk_bot(blk_bot_i),
    .blk_col(blk_col_i), .ld_en(lm_rd_en_o), .ld_row(lm_rd_row_o),
    .ld_mask(upper_ld_o), .upd_mask(upper_upd_o), .hold(lm_hold_o));

  nbc_left_ctl #(.MB_BLKS(MB_BLKS), .BLK_PIX(BLK_PIX)) u_left (
    .clk(clk), .rst_n(rst_n), .cur_field(cur_field), .blk_valid(blk_valid_i),
    .blk_bot(blk_bot_i), .blk_row(blk_row_i), .upd_mask(left_upd_o));

  assign lm_wr_bank_o = !lm_rd_bank_o;

  a_r10_write_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
    pair_start_i |=> lm_wr_bank_o == $past(lm_rd_bank_o));
endmodule

// File: tb/test_nbr_buf_ctrl.sv
module test_nbr_buf_ctrl;
  localparam int PAIRS = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pair_start = 0, pair_field = 0, left_field = 0, bot_start = 0;
  logic blk_valid = 0, blk_bot = 0;
  logic [1:0] blk_row = 0, blk_col = 0;
  logic [7:0] upper_ld, upper_upd;
  logic [15:0] left_upd;
  logic corner_reuse, corner_reload, rd_en, rd_row, rd_bank, wr_bank, hold;
  logic [1:0] rd_addr, wr_addr;
  int checks = 0, fails = 0, pair_no = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nbr_buf_ctrl #(.PAIRS_PER_ROW(PAIRS)) i_nbr_buf_ctrl (
    .clk(clk), .rst_n(rst_n), .pair_start_i(pair_start), .pair_field_i(pair_field),
    .left_field_i(left_field), .bot_start_i(bot_start), .blk_valid_i(blk_valid),
    .blk_bot_i(blk_bot), .blk_row_i(blk_row), .blk_col_i(blk_col),
    .upper_ld_o(upper_ld), .upper_upd_o(upper_upd), .left_upd_o(left_upd),
    .corner_reuse_o(corner_reuse), .corner_reload_o(corner_reload),
    .lm_rd_en_o(rd_en), .lm_rd_row_o(rd_row), .lm_rd_bank_o(rd_bank),
    .lm_rd_addr_o(rd_addr), .lm_wr_bank_o(wr_bank), .lm_wr_addr_o(wr_addr),
    .lm_hold_o(hold));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic next_cycle();
    @(posedge clk); #1;
  endtask

  // R11: quiet state after reset
  task automatic t_reset();
    chk("R11 upper load", 32'(upper_ld), 0);
    chk("R11 upper upd", 32'(upper_upd), 0);
    chk("R11 left upd", 32'(left_upd), 0);
    chk("R11 rd_en", 32'(rd_en), 0);
    chk("R11 hold", 32'(hold), 0);
    chk("R11 corner reuse", 32'(corner_reuse), 0);
    chk("R11 corner reload", 32'(corner_reload), 0);
  endtask

  task automatic t_start(input bit cur, input bit left);
    pair_field = cur; left_field = left; pair_start = 1;
    next_cycle();
    pair_start = 0;
    chk("R7 reuse", 32'(corner_reuse), 32'(cur == left));
    chk("R7 reload", 32'(corner_reload), 32'(cur != left));
    chk("R10 rd bank", 32'(rd_bank), 32'(pair_no % 2));
    chk("R10 wr bank", 32'(wr_bank), 32'(1 - pair_no % 2));
    chk("R10 rd addr", 32'(rd_addr), 32'(pair_no % PAIRS));
    chk("R10 wr addr", 32'(wr_addr), 32'((pair_no + 1) % PAIRS));
    chk("R2 first read", {rd_en, rd_row}, 2'b10);
    chk("R2 first mask", 32'(upper_ld), 32'h0F);
    chk("R9 hold set", 32'(hold), 1);
    next_cycle();
    chk("R7 reload pulse ends", 32'(corner_reload), 0);
    if (cur) begin
      chk("R2 second read", {rd_en, rd_row}, 2'b11);
      chk("R2 second mask", 32'(upper_ld), 32'hF0);
      next_cycle();
    end
    chk("R2 reads done", 32'(rd_en), 0);
    chk("R2 mask idle", 32'(upper_ld), 0);
    pair_no++;
  endtask

  task automatic t_block(input bit field, input bit bot, input int row, input int col);
    logic [7:0] eu;
    logic [15:0] el;
    eu = field ? ((bot ? 8'h10 : 8'h01) << col) : (8'h11 << col);
    el = (field ? (bot ? 16'hA : 16'h5) : 16'hF) << (4 * row);
    blk_valid = 1; blk_bot = bot; blk_row = 2'(row); blk_col = 2'(col);
    #2;
    chk(field ? "R4 upper field" : "R3 upper frame", 32'(upper_upd), 32'(eu));
    chk(field ? "R6 left field" : "R5 left frame", 32'(left_upd), 32'(el));
    next_cycle();
    blk_valid = 0;
  endtask

  task automatic t_bottom(input bit cur);
    bot_start = 1;
    next_cycle();
    bot_start = 0;
    chk("R8 bottom reuse", 32'(corner_reuse), 32'(!cur));
    chk("R8 bottom reload", 32'(corner_reload), 32'(cur));
  endtask

  // one full pair; flip drives the opposite mode after sampling (R1)
  task automatic t_pair(input bit cur, input bit left, input bit flip);
    t_start(cur, left);
    if (flip) begin pair_field = !cur; left_field = !left; end
    for (int n = 0; n < 7; n++) begin
      chk("R9 hold level", 32'(hold), 32'(n < 5));
      t_block(cur, 0, n / 4, n % 4);
    end
    if (flip) chk("R1 corner unchanged", 32'(corner_reuse), 32'(cur == left));
    t_bottom(cur);
    for (int n = 0; n < 4; n++) t_block(cur, 1, 3 - n, n);
    chk("R9 hold stays low", 32'(hold), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    next_cycle();
    t_reset();
    t_pair(0, 0, 0);
    t_pair(0, 1, 1);
    t_pair(1, 0, 0);
    t_pair(1, 1, 1);
    t_pair(1, 0, 1);
    t_pair(0, 1, 0);
    t_pair(0, 0, 1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule